// File: doc/BRIEF.md
# Wake-up exit delay sequencer

This block decides how long a processor core must wait after a wake event from a sleep or idle state before it may execute again, and it keeps two clock-ready status flags up to date while it waits. The wait depends on two things. One is the clock source that was running before the wake. The other is the source the core will run from afterwards. A crystal oscillator that must restart needs a start-up count. A crystal followed by a PLL needs that count plus a lock count. An external clock or RC source needs nothing extra. The internal oscillator has its own stabilisation interval, and execution does not wait for it.

A fixed CPU-preparation delay applies to every wake. It runs at the same time as any longer delay, so the execution point is the longer of the two and not their sum. All delays are parameters counted in reference clock cycles. A parameter of zero acts as one cycle. The sequencer reads the source selections and the internal-oscillator enable controls only on the cycle it accepts a wake. It ignores further wakes until every timer it started has expired.

Top module: `wake_exit_seq`

Timing convention: a wake is accepted at the rising edge W where `wake_i` is high and no sequence is active. "After N cycles" means the output changes at edge W+N. Here P, O, L and S are the preparation, start-up, lock and stabilisation counts, each with zero taken as one. Prior-source codes: 0 = all clocks stopped, 1 = primary kept running, 2 = secondary low-power source, 3 = internal oscillator. New-source codes: 0 = crystal, 1 = crystal with PLL, 2 = external clock or RC, 3 = internal oscillator.

## Requirements
- R1: With prior code 1 and a new code of 0, 1 or 2, `exec_go_o` pulses after P cycles and `pri_ready_o` is high from edge W onward.
- R2: With new code 0 and a prior code other than 1, `pri_ready_o` falls at W if it was set, rises after O cycles, and `exec_go_o` pulses after max(P, O) cycles.
- R3: With new code 1 and a prior code other than 1, `pri_ready_o` rises after O+L cycles and `exec_go_o` pulses after max(P, O+L) cycles.
- R4: With new code 2 and a prior code other than 1, `pri_ready_o` falls at W if it was set and rises together with the `exec_go_o` pulse after P cycles.
- R5: With new code 3, the internal oscillator enabled and not already stable from prior code 3, `int_stable_o` falls at W if set and rises after S cycles, while `exec_go_o` pulses after P cycles whatever S is.
- R6: With new code 3, prior code 3, the oscillator enabled and `int_stable_o` already high, `int_stable_o` stays high and only the P-cycle delay applies.
- R7: The internal oscillator is enabled when `irc_freq_i` is non-zero or `irc_src_i` is 1; with new code 3 and both clear, `int_stable_o` is low from W and does not rise.
- R8: A wake with new code 3 drives `pri_ready_o` low at edge W.
- R9: A wake that arrives while any delay of an accepted sequence is still counting changes no output.
- R10: A delay parameter of zero behaves as a one-cycle delay.
- R11: While `rst_n` is low, all three outputs are low after the next clock edge.
- R12: `exec_go_o` is high for exactly one cycle per accepted wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that all delays are counted in |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_i | input | 1 | Wake request, sampled on each rising edge |
| prior_src_i | input | 2 | Clock source before the wake (codes as above) |
| new_src_i | input | 2 | Clock source after the wake (codes as above) |
| irc_freq_i | input | FREQ_W | Internal oscillator frequency select; non-zero enables it |
| irc_src_i | input | 1 | Internal oscillator source select; 1 enables it |
| exec_go_o | output | 1 | One-cycle pulse: execution may resume |
| pri_ready_o | output | 1 | Primary clock ready flag |
| int_stable_o | output | 1 | Internal oscillator stable flag |

## Verification
The main instance is built with preparation 3, start-up 10, lock 5 and stabilisation 20 cycles. With these values the preparation delay is shorter than the crystal delay and far shorter than the stabilisation interval. This makes the overlap rule visible: the execution pulse lands on the start-up expiry for crystals, and well before the stable flag for the internal oscillator. A second instance has every count at zero, so the one-cycle floor and the two-cycle crystal-plus-lock path can be checked. The long stabilisation window also leaves room to inject an extra wake while the sequence is active.

// File: rtl/wake_seq_pkg.sv
// Package: shared source encodings and constant helpers for the wake-up
// exit delay sequencer. Assumes all counts are small non-negative integers.
package wake_seq_pkg;

    // Clock source that was running before the wake event
    typedef enum logic [1:0] {
        PRIOR_STOPPED   = 2'd0,
        PRIOR_PRI_RUN   = 2'd1,
        PRIOR_SECONDARY = 2'd2,
        PRIOR_INTERNAL  = 2'd3
    } prior_src_e;

    // Clock source selected for execution after the wake event
    typedef enum logic [1:0] {
        NEW_CRYSTAL     = 2'd0,
        NEW_CRYSTAL_PLL = 2'd1,
        NEW_EXTERNAL    = 2'd2,
        NEW_INTERNAL    = 2'd3
    } new_src_e;

    // A requested count of zero is served as a single cycle
    function automatic int unsigned eff_cycles(input int unsigned n);
        return (n == 0) ? 1 : n;
    endfunction

    // Larger of two counts
    function automatic int unsigned max_cycles(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..maxv
    function automatic int unsigned count_width(input int unsigned maxv);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(maxv)) w++;
        return w;
    endfunction

endpackage

// File: rtl/wake_delay_timer.sv
// Module: one down-counting delay timer.
// Loading length D at edge k makes fire_o high in the cycle before edge k+D,
// so a register sampling fire_o changes exactly at edge k+D.
// Assumes len_i is non-zero and that the owner never reloads a busy timer.
module wake_delay_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             fire_o,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded length to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= len_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Last counting cycle and activity indication
    always_comb begin
        fire_o = (cnt_q == CNT_W'(1));
        busy_o = (cnt_q != '0);
    end

    // R9: the sequencer never restarts a timer that is still counting
    a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

    // R10: every loaded length is at least one cycle
    a_r10_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (len_i != '0));

    // R10: a one-cycle load fires in the very next cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i == CNT_W'(1)) |=> fire_o);

endmodule

// File: rtl/wake_delay_plan.sv
// Module: combinational planner. From the prior/new source pair and the
// internal oscillator controls it chooses which timers to start, their
// lengths, and which status flags to set or clear at the wake edge.
// Assumes CNT_W holds the largest effective length.
module wake_delay_plan
    import wake_seq_pkg::*;
#(
    parameter int unsigned PREP_CYC = 8,
    parameter int unsigned OST_CYC  = 1024,
    parameter int unsigned PLL_CYC  = 256,
    parameter int unsigned STAB_CYC = 64,
    parameter int unsigned FREQ_W   = 3,
    parameter int unsigned CNT_W    = 12
) (
    input  logic [1:0]        prior_src_i,
    input  logic [1:0]        new_src_i,
    input  logic [FREQ_W-1:0] irc_freq_i,
    input  logic              irc_src_i,
    input  logic              int_stable_i,
    output logic [CNT_W-1:0]  exec_len_o,
    output logic              pri_load_o,
    output logic [CNT_W-1:0]  pri_len_o,
    output logic              stab_load_o,
    output logic [CNT_W-1:0]  stab_len_o,
    output logic              pri_set_o,
    output logic              pri_clr_o,
    output logic              int_clr_o
);

    localparam int unsigned P_E       = eff_cycles(PREP_CYC);
    localparam int unsigned O_E       = eff_cycles(OST_CYC);
    localparam int unsigned L_E       = eff_cycles(PLL_CYC);
    localparam int unsigned S_E       = eff_cycles(STAB_CYC);
    localparam int unsigned XTAL_LEN  = O_E;
    localparam int unsigned PLL_LEN   = O_E + L_E;
    localparam int unsigned EXEC_XTAL = max_cycles(P_E, XTAL_LEN);
    localparam int unsigned EXEC_PLL  = max_cycles(P_E, PLL_LEN);

    prior_src_e prior_s;
    new_src_e   new_s;
    logic       pri_kept;
    logic       irc_on;

    // Decode the source selections
    always_comb begin
        prior_s  = prior_src_e'(prior_src_i);
        new_s    = new_src_e'(new_src_i);
        pri_kept = (prior_s == PRIOR_PRI_RUN);
        irc_on   = (irc_freq_i != '0) || irc_src_i;
    end

    // Pick timer loads and flag actions for the source pair
    always_comb begin
        exec_len_o  = CNT_W'(P_E);
        pri_load_o  = 1'b0;
        pri_len_o   = CNT_W'(XTAL_LEN);
        stab_load_o = 1'b0;
        stab_len_o  = CNT_W'(S_E);
        pri_set_o   = 1'b0;
        pri_clr_o   = 1'b0;
        int_clr_o   = 1'b0;
        unique case (new_s)
            NEW_CRYSTAL: begin
                if (pri_kept) begin
                    pri_set_o = 1'b1;
                end else begin
                    exec_len_o = CNT_W'(EXEC_XTAL);
                    pri_clr_o  = 1'b1;
                    pri_load_o = 1'b1;
                    pri_len_o  = CNT_W'(XTAL_LEN);
                end
            end
            NEW_CRYSTAL_PLL: begin
                if (pri_kept) begin
                    pri_set_o = 1'b1;
                end else begin
                    exec_len_o = CNT_W'(EXEC_PLL);
                    pri_clr_o  = 1'b1;
                    pri_load_o = 1'b1;
                    pri_len_o  = CNT_W'(PLL_LEN);
                end
            end
            NEW_EXTERNAL: begin
                if (pri_kept) begin
                    pri_set_o = 1'b1;
                end else begin
                    pri_clr_o  = 1'b1;
                    pri_load_o = 1'b1;
                    pri_len_o  = CNT_W'(P_E);
                end
            end
            default: begin
                pri_clr_o = 1'b1;
                if (!irc_on) begin
                    int_clr_o = 1'b1;
                end else if (!(prior_s == PRIOR_INTERNAL && int_stable_i)) begin
                    int_clr_o   = 1'b1;
                    stab_load_o = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/wake_exit_seq.sv
// Module: top of the wake-up exit delay sequencer. Accepts a wake when no
// timer is active, starts the execution, primary-ready and stabilisation
// timers chosen by the planner, and owns the go pulse and status flags.
// Assumes all inputs are synchronous to clk.
module wake_exit_seq
    import wake_seq_pkg::*;
#(
    parameter int unsigned PREP_CYC = 8,
    parameter int unsigned OST_CYC  = 1024,
    parameter int unsigned PLL_CYC  = 256,
    parameter int unsigned STAB_CYC = 64,
    parameter int unsigned FREQ_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic [1:0]        prior_src_i,
    input  logic [1:0]        new_src_i,
    input  logic [FREQ_W-1:0] irc_freq_i,
    input  logic              irc_src_i,
    output logic              exec_go_o,
    output logic              pri_ready_o,
    output logic              int_stable_o
);

    localparam int unsigned CNT_W = count_width(eff_cycles(PREP_CYC) + eff_cycles(OST_CYC)
                                              + eff_cycles(PLL_CYC) + eff_cycles(STAB_CYC));
    localparam int unsigned NT     = 3;
    localparam int unsigned T_EXEC = 0;
    localparam int unsigned T_PRI  = 1;
    localparam int unsigned T_STAB = 2;

    logic [CNT_W-1:0] exec_len, pri_len, stab_len;
    logic             pri_load, stab_load, pri_set, pri_clr, int_clr;
    logic [NT-1:0]    t_load, t_fire, t_busy;
    logic [CNT_W-1:0] t_len [NT];
    logic             any_busy, accept;
    logic             go_q, pri_q, int_q;

    wake_delay_plan #(
        .PREP_CYC (PREP_CYC),
        .OST_CYC  (OST_CYC),
        .PLL_CYC  (PLL_CYC),
        .STAB_CYC (STAB_CYC),
        .FREQ_W   (FREQ_W),
        .CNT_W    (CNT_W)
    ) plan_i (
        .prior_src_i  (prior_src_i),
        .new_src_i    (new_src_i),
        .irc_freq_i   (irc_freq_i),
        .irc_src_i    (irc_src_i),
        .int_stable_i (int_q),
        .exec_len_o   (exec_len),
        .pri_load_o   (pri_load),
        .pri_len_o    (pri_len),
        .stab_load_o  (stab_load),
        .stab_len_o   (stab_len),
        .pri_set_o    (pri_set),
        .pri_clr_o    (pri_clr),
        .int_clr_o    (int_clr)
    );

    // Accept a wake only when the previous sequence has fully drained
    always_comb begin
        any_busy = |t_busy;
        accept   = wake_i && !any_busy;
    end

    // Route planner choices to the timer bank
    always_comb begin
        t_load[T_EXEC] = accept;
        t_load[T_PRI]  = accept && pri_load;
        t_load[T_STAB] = accept && stab_load;
        t_len[T_EXEC]  = exec_len;
        t_len[T_PRI]   = pri_len;
        t_len[T_STAB]  = stab_len;
    end

    for (genvar g = 0; g < NT; g++) begin : g_timer
        wake_delay_timer #(.CNT_W(CNT_W)) tmr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (t_load[g]),
            .len_i  (t_len[g]),
            .fire_o (t_fire[g]),
            .busy_o (t_busy[g])
        );
    end

    // Execution-enable pulse on expiry of the execution timer
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= t_fire[T_EXEC];
    end

    // Primary-ready flag: set/clear at wake, set on primary timer expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                  pri_q <= 1'b0;
        else if (accept && pri_set)  pri_q <= 1'b1;
        else if (accept && pri_clr)  pri_q <= 1'b0;
        else if (t_fire[T_PRI])      pri_q <= 1'b1;
    end

    // Internal-stable flag: clear at wake when needed, set on stabilisation expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                  int_q <= 1'b0;
        else if (accept && int_clr)  int_q <= 1'b0;
        else if (t_fire[T_STAB])     int_q <= 1'b1;
    end

    assign exec_go_o    = go_q;
    assign pri_ready_o  = pri_q;
    assign int_stable_o = int_q;

    // R12: execution enable lasts a single cycle
    a_r12_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go_o |=> !exec_go_o);

    // R8: a wake onto the internal oscillator drops primary-ready
    a_r8_pri_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && new_src_i == 2'd3) |=> !pri_ready_o);

    // R7: a disabled internal oscillator never reports stable
    a_r7_int_off: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && new_src_i == 2'd3 && irc_freq_i == '0 && !irc_src_i) |=> !int_stable_o);

    // R6: an already-stable internal oscillator stays stable
    a_r6_int_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && new_src_i == 2'd3 && prior_src_i == 2'd3 && int_stable_o
         && (irc_freq_i != '0 || irc_src_i)) |=> int_stable_o);

    // R1: primary kept running reports ready right after the wake
    a_r1_pri_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prior_src_i == 2'd1 && new_src_i != 2'd3) |=> pri_ready_o);

    // R11: reset clears every output on the next edge
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> (!exec_go_o && !pri_ready_o && !int_stable_o));

endmodule

// File: tb/wake_exit_seq_tb.sv
`timescale 1ns/1ps
module wake_exit_seq_tb_top;

    localparam int P = 3, O = 10, L = 5, S = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] prior = 2'd0, nsrc = 2'd0;
    logic [2:0] freq = 3'd0;
    logic       isrc = 1'b0;
    logic       go, pri, ist;

    logic       wake_z = 1'b0;
    logic [1:0] nsrc_z = 2'd0;
    logic       go_z, pri_z, ist_z;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;
    bit m_pri = 0, m_int = 0;

    typedef struct {int t; int kind; bit val; string tag;} ev_t;
    ev_t exp_q[$];
    bit prev_go = 0, prev_pri = 0, prev_int = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wake_exit_seq #(.PREP_CYC(P), .OST_CYC(O), .PLL_CYC(L), .STAB_CYC(S), .FREQ_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .wake_i(wake), .prior_src_i(prior), .new_src_i(nsrc),
        .irc_freq_i(freq), .irc_src_i(isrc),
        .exec_go_o(go), .pri_ready_o(pri), .int_stable_o(ist));

    wake_exit_seq #(.PREP_CYC(0), .OST_CYC(0), .PLL_CYC(0), .STAB_CYC(0), .FREQ_W(3)) dut_z_i (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_z), .prior_src_i(2'd0), .new_src_i(nsrc_z),
        .irc_freq_i(3'd0), .irc_src_i(1'b0),
        .exec_go_o(go_z), .pri_ready_o(pri_z), .int_stable_o(ist_z));

    function automatic int eff(int n); return (n == 0) ? 1 : n; endfunction

    // Scoreboard push in (time, kind) order
    task automatic add_ev(int t, int kind, bit val, string tag);
        ev_t e;
        int i;
        e.t = t; e.kind = kind; e.val = val; e.tag = tag;
        i = 0;
        while (i < exp_q.size() && (exp_q[i].t * 4 + exp_q[i].kind) <= (t * 4 + kind)) i++;
        exp_q.insert(i, e);
    endtask

    task automatic check(string tag, int act, int exp_v, string what);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp_v, cyc);
        end
    endtask

    // Monitor: compare every observed output change against the scoreboard
    task automatic observe(int kind, bit val);
        ev_t e;
        tests++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9 R12 unexpected event: actual kind %0d val %0d at %0d expected none",
                     kind, val, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.t != cyc || e.kind != kind || e.val != val) begin
                fails++;
                $display("FAIL %s event: actual kind %0d val %0d at %0d expected kind %0d val %0d at %0d",
                         e.tag, kind, val, cyc, e.kind, e.val, e.t);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_go = go; prev_pri = pri; prev_int = ist;
        end else begin
            if (go) observe(0, 1'b1);
            if (pri != prev_pri) observe(1, pri);
            if (ist != prev_int) observe(2, ist);
            prev_go = go; prev_pri = pri; prev_int = ist;
        end
    end

    // Driver: apply one wake and push the expected events from the requirements
    task automatic do_wake(int pr, int nw, int fq, bit sr, string tag, bit inject);
        int e, dx, end_t;
        bit en;
        @(negedge clk);
        prior = pr[1:0]; nsrc = nw[1:0]; freq = fq[2:0]; isrc = sr; wake = 1'b1;
        e = cyc + 1;
        dx = eff(P);
        end_t = 0;
        if (nw != 3 && pr == 1) begin
            if (!m_pri) add_ev(e, 1, 1'b1, tag);
            m_pri = 1;
        end else if (nw == 0 || nw == 1 || nw == 2) begin
            int pl;
            pl = (nw == 0) ? eff(O) : (nw == 1) ? eff(O) + eff(L) : eff(P);
            if (pl > dx) dx = pl;
            if (m_pri) add_ev(e, 1, 1'b0, tag);
            add_ev(e + pl, 1, 1'b1, tag);
            m_pri = 1;
        end else begin
            en = (fq != 0) || sr;
            if (m_pri) add_ev(e, 1, 1'b0, tag);
            m_pri = 0;
            if (!en) begin
                if (m_int) add_ev(e, 2, 1'b0, tag);
                m_int = 0;
            end else if (!(pr == 3 && m_int)) begin
                if (m_int) add_ev(e, 2, 1'b0, tag);
                add_ev(e + eff(S), 2, 1'b1, tag);
                end_t = e + eff(S);
                m_int = 1;
            end
        end
        add_ev(e + dx, 0, 1'b1, tag);
        if (e + dx > end_t) end_t = e + dx;
        @(negedge clk);
        wake = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            prior = 2'd1; nsrc = 2'd0; wake = 1'b1;   // R9: must be ignored
            @(negedge clk);
            wake = 1'b0;
        end
        while (cyc < end_t + 2) @(negedge clk);
        check(tag, exp_q.size(), 0, "pending expected events");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stimulus
        int e;
        repeat (3) @(negedge clk);
        check("R11", go, 0, "go in reset");
        check("R11", pri, 0, "pri_ready in reset");
        check("R11", ist, 0, "int_stable in reset");
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_wake(0, 0, 0, 1'b0, "R2", 1'b0);
        do_wake(3, 3, 3, 1'b0, "R5 R8", 1'b1);
        check("R9", ist, 1, "int_stable after ignored wake");
        do_wake(3, 3, 1, 1'b0, "R6", 1'b0);
        do_wake(3, 3, 0, 1'b0, "R7", 1'b0);
        do_wake(0, 1, 0, 1'b0, "R3", 1'b0);
        do_wake(1, 2, 0, 1'b0, "R1", 1'b0);
        do_wake(0, 2, 0, 1'b0, "R4", 1'b0);
        do_wake(2, 3, 0, 1'b1, "R5 R8", 1'b0);
        do_wake(1, 0, 0, 1'b0, "R1", 1'b0);

        // R10: zero-count instance, external clock path
        @(negedge clk); nsrc_z = 2'd2; wake_z = 1'b1; e = cyc + 1;
        @(negedge clk); wake_z = 1'b0;
        check("R10", go_z, 0, "zero go at wake edge");
        @(negedge clk);
        check("R10", go_z, 1, "zero go one cycle after wake");
        check("R10", pri_z, 1, "zero pri one cycle after wake");
        @(negedge clk);
        check("R12", go_z, 0, "zero go pulse ended");
        // R10: zero-count instance, crystal with PLL path (one plus one cycles)
        @(negedge clk); nsrc_z = 2'd1; wake_z = 1'b1;
        @(negedge clk); wake_z = 1'b0;
        check("R10", pri_z, 0, "zero pll pri at wake edge");
        @(negedge clk);
        check("R10", pri_z, 0, "zero pll pri after one cycle");
        @(negedge clk);
        check("R10", pri_z, 1, "zero pll pri after two cycles");
        check("R10", go_z, 1, "zero pll go after two cycles");
        repeat (3) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule